// File: doc/BRIEF.md
# Pulse-Gap Tag Write Modulator

This block writes an 80-bit record to a low-frequency tag by keying the reader field on and off. A one-cycle start pulse latches a 64-bit payload and a 16-bit check value. The block then holds the field on to charge the tag and sends a fixed frame of 112 bits. The frame opens with a keyword byte and a password byte, carries the payload and the check value, and closes with a two-byte write trailer. After the last bit the field stays on for a programming hold, and then a done pulse marks the end.

Each bit is a field-off gap followed by a field-on period, and both bit kinds take the same total time. The gap length tells a one from a zero. When the supplied check value is zero, the block computes it over the payload while the payload bits go out. All durations are given in microseconds and scaled by a clock-cycles-per-microsecond parameter.

Top module: `lf_pgap_writer`

## Requirements
- R1: While reset is asserted, field_o, busy_o and done_o are all 0.
- R2: A start_i pulse seen while busy_o is low raises busy_o in the next cycle, and field_o is then held at 1 for CHARGE_US*CYC_PER_US cycles.
- R3: A 1 bit is sent as field_o=0 for ONE_OFF_US*CYC_PER_US cycles, then field_o=1 for ONE_ON_US*CYC_PER_US cycles.
- R4: A 0 bit is sent as field_o=0 for ZERO_OFF_US*CYC_PER_US cycles, then field_o=1 for ZERO_ON_US*CYC_PER_US cycles.
- R5: The frame has 14 bytes in this order: 0xBB, 0xEB, eight payload bytes, the check value low byte, the check value high byte, 0x00, 0x03.
- R6: The payload bytes go out from least to most significant (data_i[7:0] first), and every byte is sent least significant bit first.
- R7: After the last frame bit, field_o stays at 1 for PROG_US*CYC_PER_US extra cycles. In the next cycle done_o is 1 for exactly one cycle, with busy_o and field_o at 0.
- R8: When crc_i is zero, the check value sent is CRC-16 with reflected polynomial 0x8408 and initial value 0. It is computed over the payload bytes from low to high, least significant bit first.
- R9: When crc_i is nonzero, it is sent unchanged, whether or not it matches the payload.
- R10: A start_i pulse while busy_o is high, including the last programming cycle, is ignored: the frame in progress and its data are unchanged, and no new frame follows.
- R11: field_o is 0 whenever busy_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start pulse; samples data_i and crc_i when the block is idle |
| data_i | input | 64 | Payload to write |
| crc_i | input | 16 | Check value to send; zero selects the internally computed value |
| field_o | output | 1 | Field control: 1 = field on, 0 = field off |
| busy_o | output | 1 | High from the cycle after an accepted start until done |
| done_o | output | 1 | One-cycle pulse when the programming hold ends |

## Verification
The done pulse and the acceptance of a new start can fall in the same cycle: busy_o is already low while done_o is high. The bench asserts start_i in exactly that cycle, and the scoreboard must then decode a complete second frame that begins in the next cycle. The opposite edge case is a start in the final programming cycle, while busy_o is still high. The bench counts the frame length to place the pulse there, and it passes only if done_o follows one cycle later and busy_o then stays low.

// File: rtl/pgw_pkg.sv
`timescale 1ns/1ps
package pgw_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_CHARGE = 3'd1,
    PH_GAP    = 3'd2,
    PH_ON     = 3'd3,
    PH_PROG   = 3'd4
  } phase_e;

  localparam logic [7:0]  HDR_KEY      = 8'hBB;
  localparam logic [7:0]  HDR_PASS     = 8'hEB;
  localparam logic [7:0]  TRL_LO       = 8'h00;
  localparam logic [7:0]  TRL_HI       = 8'h03;
  localparam int unsigned PAYLOAD_BITS = 64;
  localparam int unsigned CHK_BITS     = 16;
  localparam int unsigned FRAME_BITS   = 16 + PAYLOAD_BITS + CHK_BITS + 16;
  localparam logic [15:0] CHK_POLY_REF = 16'h8408;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pgw_timer.sv
`timescale 1ns/1ps
module pgw_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? load_val_i : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/pgw_crc16.sv
`timescale 1ns/1ps
module pgw_crc16
  import pgw_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        step_i,
  input  logic        bit_i,
  output logic [15:0] crc_o
);

  logic [15:0] crc_q, crc_d;
  logic        crc_en;
  logic        fb;

  always_comb begin
    fb     = crc_q[0] ^ bit_i;
    crc_en = clr_i || step_i;
    if (clr_i) crc_d = '0;
    else       crc_d = (crc_q >> 1) ^ (fb ? CHK_POLY_REF : 16'h0000);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '0;
    else if (crc_en) crc_q <= crc_d;
  end

  assign crc_o = crc_q;

endmodule

// File: rtl/pgw_bitseq.sv
`timescale 1ns/1ps
module pgw_bitseq
  import pgw_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    adv_i,
  input  logic [PAYLOAD_BITS-1:0] data_i,
  input  logic [CHK_BITS-1:0]     chk_i,
  output logic                    bit_o,
  output logic                    nxt_bit_o,
  output logic                    is_data_o,
  output logic                    last_o
);

  localparam int unsigned IW = $clog2(FRAME_BITS);
  localparam logic [IW-1:0] DATA_LO = IW'(16);
  localparam logic [IW-1:0] DATA_HI = IW'(16 + PAYLOAD_BITS);
  localparam logic [IW-1:0] LAST_IX = IW'(FRAME_BITS - 1);

  logic [IW-1:0]         idx_q, idx_d;
  logic                  idx_en;
  logic [FRAME_BITS-1:0] frame;

  // bit 0 of the vector leaves first: headers, payload, check value, trailer
  assign frame = {TRL_HI, TRL_LO, chk_i, data_i, HDR_PASS, HDR_KEY};

  always_comb begin
    idx_en = clr_i || adv_i;
    idx_d  = clr_i ? '0 : (idx_q + 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign last_o    = (idx_q == LAST_IX);
  assign bit_o     = frame[idx_q];
  assign nxt_bit_o = last_o ? 1'b0 : frame[idx_q + 1'b1];
  assign is_data_o = (idx_q >= DATA_LO) && (idx_q < DATA_HI);

endmodule

// File: rtl/lf_pgap_writer.sv
`timescale 1ns/1ps
module lf_pgap_writer
  import pgw_pkg::*;
#(
  parameter int unsigned CYC_PER_US  = 16,
  parameter int unsigned ONE_OFF_US  = 1000,
  parameter int unsigned ONE_ON_US   = 1000,
  parameter int unsigned ZERO_OFF_US = 300,
  parameter int unsigned ZERO_ON_US  = 1700,
  parameter int unsigned CHARGE_US   = 50000,
  parameter int unsigned PROG_US     = 50000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [63:0] data_i,
  input  logic [15:0] crc_i,
  output logic        field_o,
  output logic        busy_o,
  output logic        done_o
);

  localparam int unsigned ONE_OFF_C  = ONE_OFF_US  * CYC_PER_US;
  localparam int unsigned ONE_ON_C   = ONE_ON_US   * CYC_PER_US;
  localparam int unsigned ZERO_OFF_C = ZERO_OFF_US * CYC_PER_US;
  localparam int unsigned ZERO_ON_C  = ZERO_ON_US  * CYC_PER_US;
  localparam int unsigned CHARGE_C   = CHARGE_US   * CYC_PER_US;
  localparam int unsigned PROG_C     = PROG_US     * CYC_PER_US;
  localparam int unsigned MAX_C = umax(umax(umax(ONE_OFF_C, ONE_ON_C), umax(ZERO_OFF_C, ZERO_ON_C)),
                                       umax(CHARGE_C, PROG_C));
  localparam int unsigned CW = $clog2(MAX_C + 1);

  localparam logic [CW-1:0] LD_ONE_OFF  = CW'(ONE_OFF_C - 1);
  localparam logic [CW-1:0] LD_ONE_ON   = CW'(ONE_ON_C - 1);
  localparam logic [CW-1:0] LD_ZERO_OFF = CW'(ZERO_OFF_C - 1);
  localparam logic [CW-1:0] LD_ZERO_ON  = CW'(ZERO_ON_C - 1);
  localparam logic [CW-1:0] LD_CHARGE   = CW'(CHARGE_C - 1);
  localparam logic [CW-1:0] LD_PROG     = CW'(PROG_C - 1);

  // reset: asserted at once, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  phase_e      ph_q, ph_d;
  logic        done_q, done_d;
  logic [63:0] data_q;
  logic [15:0] crc_q;
  logic        cap_en;
  logic        tm_load, tm_zero;
  logic [CW-1:0] tm_val;
  logic        seq_clr, seq_adv;
  logic        cur_bit, nxt_bit, is_data, last_bit;
  logic        crc_clr, crc_step;
  logic [15:0] crc_gen, crc_sel;

  assign crc_sel = (crc_q == 16'h0000) ? crc_gen : crc_q;

  pgw_timer #(.W(CW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .load_i     (tm_load),
    .load_val_i (tm_val),
    .zero_o     (tm_zero)
  );

  pgw_bitseq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .clr_i     (seq_clr),
    .adv_i     (seq_adv),
    .data_i    (data_q),
    .chk_i     (crc_sel),
    .bit_o     (cur_bit),
    .nxt_bit_o (nxt_bit),
    .is_data_o (is_data),
    .last_o    (last_bit)
  );

  pgw_crc16 u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .clr_i  (crc_clr),
    .step_i (crc_step),
    .bit_i  (cur_bit),
    .crc_o  (crc_gen)
  );

  always_comb begin
    ph_d     = ph_q;
    done_d   = 1'b0;
    cap_en   = 1'b0;
    tm_load  = 1'b0;
    tm_val   = '0;
    seq_clr  = 1'b0;
    seq_adv  = 1'b0;
    crc_clr  = 1'b0;
    crc_step = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (start_i) begin
        cap_en  = 1'b1;
        seq_clr = 1'b1;
        crc_clr = 1'b1;
        tm_load = 1'b1;
        tm_val  = LD_CHARGE;
        ph_d    = PH_CHARGE;
      end
      PH_CHARGE: if (tm_zero) begin
        tm_load = 1'b1;
        tm_val  = cur_bit ? LD_ONE_OFF : LD_ZERO_OFF;
        ph_d    = PH_GAP;
      end
      PH_GAP: if (tm_zero) begin
        tm_load  = 1'b1;
        tm_val   = cur_bit ? LD_ONE_ON : LD_ZERO_ON;
        crc_step = is_data;
        ph_d     = PH_ON;
      end
      PH_ON: if (tm_zero) begin
        tm_load = 1'b1;
        if (last_bit) begin
          tm_val = LD_PROG;
          ph_d   = PH_PROG;
        end else begin
          seq_adv = 1'b1;
          tm_val  = nxt_bit ? LD_ONE_OFF : LD_ZERO_OFF;
          ph_d    = PH_GAP;
        end
      end
      PH_PROG: if (tm_zero) begin
        done_d = 1'b1;
        ph_d   = PH_IDLE;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      ph_q   <= PH_IDLE;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      data_q <= '0;
      crc_q  <= '0;
    end else if (cap_en) begin
      data_q <= data_i;
      crc_q  <= crc_i;
    end
  end

  assign busy_o  = (ph_q != PH_IDLE);
  assign field_o = (ph_q == PH_CHARGE) || (ph_q == PH_ON) || (ph_q == PH_PROG);
  assign done_o  = done_q;

endmodule

// File: rtl/pgw_writer_chk.sv
`timescale 1ns/1ps
module pgw_writer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        field_o,
  input logic [63:0] cap_data
);

  AST_START_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && field_o)); // R2

  AST_IDLE_FIELD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !field_o); // R11

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))); // R7

  AST_PROG_FIELD_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(field_o)); // R7

  AST_BUSY_HOLDS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(cap_data)); // R10

endmodule

bind lf_pgap_writer pgw_writer_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_n_int),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .field_o  (field_o),
  .cap_data (data_q)
);

// File: tb/test_lf_pgap_writer.sv
`timescale 1ns/1ps
module test_lf_pgap_writer;

  localparam int CPU   = 1;
  localparam int T1OFF = 10;
  localparam int T1ON  = 10;
  localparam int T0OFF = 3;
  localparam int T0ON  = 17;
  localparam int TCH   = 50;
  localparam int TPR   = 50;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start = 1'b0;
  logic [63:0] data = '0;
  logic [15:0] crc = '0;
  logic        field, busy, done;

  int total = 0;
  int bad = 0;
  logic  exp_bits[$];
  string exp_tag[$];

  always #2.5 clk = ~clk;

  lf_pgap_writer #(
    .CYC_PER_US(CPU), .ONE_OFF_US(T1OFF), .ONE_ON_US(T1ON),
    .ZERO_OFF_US(T0OFF), .ZERO_ON_US(T0ON), .CHARGE_US(TCH), .PROG_US(TPR)
  ) i_lf_pgap_writer (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .data_i(data), .crc_i(crc),
    .field_o(field), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // byte-wise reflected CCITT update, initial value 0
  function automatic logic [15:0] crc_ref(input logic [63:0] d);
    logic [15:0] c = 16'h0000;
    logic [7:0]  t;
    for (int k = 0; k < 8; k++) begin
      t = d[8*k +: 8] ^ c[7:0];
      t = t ^ (t << 4);
      c = (c >> 8) ^ {t, 8'h00} ^ ({8'h00, t} << 3) ^ ({8'h00, t} >> 4);
    end
    return c;
  endfunction

  function automatic logic [111:0] frame_vec(input logic [63:0] d, input logic [15:0] c);
    logic [15:0] cs = (c == 16'h0000) ? crc_ref(d) : c;
    return {8'h03, 8'h00, cs, d, 8'hEB, 8'hBB};
  endfunction

  function automatic int frame_cycles(input logic [63:0] d, input logic [15:0] c);
    logic [111:0] f = frame_vec(d, c);
    int n = TCH + TPR;
    for (int k = 0; k < 112; k++) n += f[k] ? (T1OFF + T1ON) : (T0OFF + T0ON);
    return n;
  endfunction

  task automatic push_frame(input logic [63:0] d, input logic [15:0] c);
    logic [111:0] f = frame_vec(d, c);
    for (int k = 0; k < 112; k++) begin
      exp_bits.push_back(f[k]);
      if (k < 16 || k >= 96) exp_tag.push_back("R5");
      else if (k < 80)       exp_tag.push_back("R6");
      else                   exp_tag.push_back((c == 16'h0000) ? "R8" : "R9");
    end
  endtask

  task automatic send(input logic [63:0] d, input logic [15:0] c);
    @(negedge clk);
    data = d; crc = c; start = 1'b1;
    push_frame(d, c);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (done !== 1'b1);
  endtask

  task automatic send_in_done(input logic [63:0] d, input logic [15:0] c);
    wait_done();
    data = d; crc = c; start = 1'b1;
    push_frame(d, c);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic count_run(input logic v, output int n);
    n = 0;
    while (field === v) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic run_frame();
    int n, off, onr, exp_on;
    logic b, dec;
    string tg;
    count_run(1'b1, n);
    chk(n == TCH, "R2", "charge length", n, TCH);
    for (int k = 0; k < 112; k++) begin
      if (exp_bits.size() == 0) begin
        chk(1'b0, "R5", "frame with no expected bits", k, 0);
        return;
      end
      b  = exp_bits.pop_front();
      tg = exp_tag.pop_front();
      count_run(1'b0, off);
      count_run(1'b1, onr);
      dec = (off == T1OFF);
      chk(dec == b, tg, $sformatf("bit %0d value", k), dec, b);
      exp_on = b ? T1ON : T0ON;
      if (k == 111) begin
        chk(off == T0OFF && onr == exp_on + TPR, "R7", "last bit plus programming hold",
            onr, exp_on + TPR);
      end else if (b) begin
        chk(off == T1OFF && onr == T1ON, "R3", $sformatf("bit %0d one timing", k),
            off * 1000 + onr, T1OFF * 1000 + T1ON);
      end else begin
        chk(off == T0OFF && onr == T0ON, "R4", $sformatf("bit %0d zero timing", k),
            off * 1000 + onr, T0OFF * 1000 + T0ON);
      end
    end
    chk(done === 1'b1 && busy === 1'b0, "R7", "done pulse with busy low",
        {done, busy}, 2'b10);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_ni && busy === 1'b1) run_frame();
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R7", "watchdog expired before completion", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int tlen;
    repeat (3) @(negedge clk);
    chk(field === 1'b0 && busy === 1'b0 && done === 1'b0, "R1", "outputs in reset",
        {field, busy, done}, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk(field === 1'b0, "R11", "idle field", field, 0);

    // generated check value over a mixed payload
    send(64'h0123_4567_89AB_CDEF, 16'h0000);
    wait_done();

    // wrong check value sent verbatim, plus a start in mid frame
    send(64'h8000_0000_0000_0001, 16'h1234);
    repeat (300) @(negedge clk);
    data = 64'hDEAD_BEEF_CAFE_F00D; crc = 16'hFFFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R10", "busy after ignored start", busy, 1);

    // new start in the done cycle of the previous frame
    send_in_done(64'hFFFF_FFFF_FFFF_FFFF, 16'h0000);

    // start in the last programming cycle is ignored
    tlen = frame_cycles(64'hFFFF_FFFF_FFFF_FFFF, 16'h0000);
    repeat (tlen - 1) @(negedge clk);
    chk(busy === 1'b1, "R10", "busy in last programming cycle", busy, 1);
    data = 64'h1111_2222_3333_4444; crc = 16'h5555; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done === 1'b1, "R7", "done after programming hold", done, 1);
    @(negedge clk);
    chk(busy === 1'b0, "R10", "no frame after late start", busy, 0);
    repeat (3) @(negedge clk);
    chk(field === 1'b0, "R11", "field low after frame", field, 0);

    // all-zero payload: generated check value is zero
    send(64'h0, 16'h0000);
    wait_done();
    repeat (5) @(negedge clk);
    chk(exp_bits.size() == 0, "R5", "bits left in scoreboard", exp_bits.size(), 0);
    chk(busy === 1'b0 && field === 1'b0, "R11", "final idle", {busy, field}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule